// File: doc/BRIEF.md
# Byte-Serial DAC Frame Adapter

This block feeds a 16-bit serial DAC from a byte-oriented shift engine. The engine inside the adapter moves one byte at a time and shifts the least significant bit out first. The DAC needs the whole 16-bit word with the most significant bit first. To get that order, the adapter sends the upper byte first and reverses the bit order of each byte before loading it into the engine. It keeps the DAC's chip select low across the byte boundary, so the DAC sees one continuous 16-clock frame. It raises chip select only after the last bit of the second byte.

Words arrive on a valid/ready stream. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. The source must hold `in_valid` and `in_data` until that edge. While a frame is in flight, plus a short guard time, `in_ready` stays low and any `in_valid` is ignored. Input words narrower than the frame are left-aligned, and the low end is filled with zeros. The serial clock comes from the system clock through a divider parameter. It idles low and rises in the middle of each bit, so data launched on the falling edge is stable when the DAC samples it.

A plain mode pin chooses how the DAC register updates. With the pin low, a load strobe pulses low for one serial period after each frame. With the pin high, the strobe is held low, so the DAC updates on the rising edge of chip select.

Top module: `dac_frame_adapter`

## Requirements
- R1: After reset, `dac_cs_n` is 1, `dac_sclk` is 0, `in_ready` is 1, and with `auto_load`=0, `dac_ldac_n` is 1.
- R2: A word is accepted only on an edge with `in_valid`=1 and `in_ready`=1. `in_ready` is 0 from the next cycle until the frame and its guard time end. An `in_valid` pulse while `in_ready`=0 starts no frame.
- R3: During one chip-select-low window, `dac_sdo` sampled at the rising edges of `dac_sclk` gives the frame word from bit 15 down to bit 0.
- R4: The frame word is `in_data` placed in bits 15 down to 16-DATA_W, with all lower bits zero.
- R5: `dac_cs_n` stays low without a break for exactly 16 rising edges of `dac_sclk`, across the byte boundary, and rises after the 16th falling edge.
- R6: `dac_sclk` is 0 whenever `dac_cs_n` is 1. `dac_sdo` changes only while `dac_sclk` is 0.
- R7: Each high phase and each low phase of `dac_sclk` within a frame lasts SCLK_HALF system clock cycles.
- R8: `dac_cs_n` stays high for at least 4*SCLK_HALF cycles (two serial periods) between frames.
- R9: With `auto_load`=0, `dac_ldac_n` stays 1 while `dac_cs_n` is low. It goes low when `dac_cs_n` rises and stays low for exactly 2*SCLK_HALF cycles.
- R10: With `auto_load`=1, `dac_ldac_n` is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Adapter can take a word |
| in_data | input | DATA_W | Input word, left-aligned into the frame |
| auto_load | input | 1 | 1: load strobe held low; 0: strobe pulsed after each frame |
| dac_sclk | output | 1 | Serial clock to the DAC, idle low |
| dac_sdo | output | 1 | Serial data to the DAC, MSB of the frame first |
| dac_cs_n | output | 1 | Active-low frame select |
| dac_ldac_n | output | 1 | Active-low load strobe |

## Verification
A wrong byte-select or bit-counter state shows up within the same frame as a swapped or mirrored byte on the data line. It also shows as a clock-edge count other than 16 at the next rise of chip select. A divider or guard counter that is out of step shows up at the next serial clock phase or the next inter-frame gap as a wrong duration. A stuck frame state shows up as `in_ready` never returning or as a missing load pulse.

// File: rtl/dfa_pkg.sv
package dfa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_POST  = 2'd2
  } dfa_state_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/dfa_tick_gen.sv
module dfa_tick_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assert_div_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < HALF);

  assert_div_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/dfa_byte_rev.sv
module dfa_byte_rev #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = din[W-1-i];
  end
endmodule

// File: rtl/dfa_lsb_shifter.sv
module dfa_lsb_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         dout
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= din;
    else if (shift) sh_q <= {1'b0, sh_q[W-1:1]};
  end

  assign dout = sh_q[0];

  assert_load_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));
endmodule

// File: rtl/dac_frame_adapter.sv
module dac_frame_adapter
  import dfa_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int FRAME_W    = 16,
  parameter int SCLK_HALF  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              auto_load,
  output logic              dac_sclk,
  output logic              dac_sdo,
  output logic              dac_cs_n,
  output logic              dac_ldac_n
);
  localparam int NB          = FRAME_W / BYTE_W;
  localparam int BIT_W       = $clog2(FRAME_W);
  localparam int PAD_W       = FRAME_W - DATA_W;
  localparam int POST_TICKS  = 4;
  localparam int LDAC_TICKS  = 2;
  localparam int SEL_W       = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  dfa_state_e        state_q;
  logic [FRAME_W-1:0] frame_q;
  logic [BIT_W-1:0]  bit_idx_q;
  logic [1:0]        post_cnt_q;
  logic              sclk_q;
  logic              cs_n_q;
  logic              tick;

  logic               accept;
  logic [FRAME_W-1:0] padded;
  logic [FRAME_W-1:0] src;
  logic [BYTE_W-1:0]  rev_b [NB];
  logic               fall_adv;
  logic               byte_load;
  logic [SEL_W-1:0]   byte_sel;
  logic [BYTE_W-1:0]  eng_din;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign padded   = FRAME_W'(in_data) << PAD_W;
  assign src      = accept ? padded : frame_q;

  for (genvar b = 0; b < NB; b++) begin : g_rev
    dfa_byte_rev #(.W(BYTE_W)) u_rev (
      .din  (src[b*BYTE_W +: BYTE_W]),
      .dout (rev_b[b])
    );
  end

  dfa_tick_gen #(.HALF(SCLK_HALF)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q != ST_IDLE),
    .tick  (tick)
  );

  assign fall_adv  = (state_q == ST_SHIFT) && tick && sclk_q && (bit_idx_q != LAST_BIT);
  assign byte_load = fall_adv && (bit_idx_q[2:0] == 3'd7);

  always_comb begin
    int nxt;
    nxt = (32'(bit_idx_q) + 1) / BYTE_W;
    if (accept) byte_sel = SEL_W'(NB - 1);
    else        byte_sel = SEL_W'(NB - 1 - nxt);
    eng_din = rev_b[byte_sel];
  end

  dfa_lsb_shifter #(.W(BYTE_W)) u_eng (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept || byte_load),
    .shift (fall_adv && !byte_load),
    .din   (eng_din),
    .dout  (dac_sdo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      frame_q    <= '0;
      bit_idx_q  <= '0;
      post_cnt_q <= '0;
      sclk_q     <= 1'b0;
      cs_n_q     <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            frame_q   <= padded;
            bit_idx_q <= '0;
            cs_n_q    <= 1'b0;
            sclk_q    <= 1'b0;
            state_q   <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
            end else begin
              sclk_q <= 1'b0;
              if (bit_idx_q == LAST_BIT) begin
                cs_n_q     <= 1'b1;
                post_cnt_q <= '0;
                state_q    <= ST_POST;
              end else begin
                bit_idx_q <= bit_idx_q + 1'b1;
              end
            end
          end
        end
        ST_POST: begin
          if (tick) begin
            if (post_cnt_q == 2'(POST_TICKS - 1)) state_q <= ST_IDLE;
            else                                  post_cnt_q <= post_cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dac_sclk   = sclk_q;
  assign dac_cs_n   = cs_n_q;
  assign dac_ldac_n = auto_load ? 1'b0
                    : !((state_q == ST_POST) && (32'(post_cnt_q) < LDAC_TICKS));

  assert_sclk_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dac_cs_n |-> !dac_sclk);

  assert_sdo_low_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_sdo) |-> !dac_sclk);

  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && !dac_cs_n));

  assert_cs_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_cs_n) |-> ($past(bit_idx_q) == LAST_BIT));

  assert_no_ldac_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_load && !dac_cs_n) |-> dac_ldac_n);

  assert_guard_before_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> ($past(post_cnt_q) == 2'(POST_TICKS - 1)));
endmodule

// File: tb/sim_dac_frame_adapter.sv
module sim_dac_frame_adapter;
  localparam int DATA_W = 12;
  localparam int HALF   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic auto_load = 1'b0;
  logic dac_sclk, dac_sdo, dac_cs_n, dac_ldac_n;

  int n_checks = 0;
  int n_fail = 0;
  int frames_sent = 0;
  int frames_seen = 0;
  logic [15:0] exp_word = '0;

  always #5 clk = ~clk;

  dac_frame_adapter #(.DATA_W(DATA_W), .FRAME_W(16), .SCLK_HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .auto_load(auto_load), .dac_sclk(dac_sclk),
    .dac_sdo(dac_sdo), .dac_cs_n(dac_cs_n), .dac_ldac_n(dac_ldac_n)
  );

  function automatic logic [15:0] frame_of(input logic [DATA_W-1:0] d);
    return 16'(d) << (16 - DATA_W);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // DAC-side model, sampled at negedge
  logic p_sclk = 1'b0, p_cs = 1'b1, p_ldac = 1'b1;
  int bits = 0, hi_cnt = 0, gap = 1000, ld_cnt = 0;
  logic [15:0] shreg = '0;
  bit ready_bad = 0, ld_early = 0, auto_bad = 0, ld_pend = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dac_cs_n && dac_sclk) check(0, "R6 sclk high while cs high", 1, 0);
      if (dac_cs_n) gap++;
      if (p_cs && !dac_cs_n) begin
        check(gap >= 4*HALF, "R8 cs high gap", gap, 4*HALF);
        bits = 0; shreg = '0; ready_bad = 0; ld_early = 0; auto_bad = 0;
      end
      if (!dac_cs_n && in_ready) ready_bad = 1;
      if (!dac_cs_n && !auto_load && !dac_ldac_n) ld_early = 1;
      if (auto_load && dac_ldac_n) auto_bad = 1;
      if (!p_sclk && dac_sclk && !dac_cs_n) begin
        shreg = {shreg[14:0], dac_sdo};
        bits++;
      end
      if (dac_sclk) hi_cnt++;
      if (p_sclk && !dac_sclk) begin
        check(hi_cnt == HALF, "R7 sclk high width", hi_cnt, HALF);
        hi_cnt = 0;
      end
      if (!p_cs && dac_cs_n) begin
        frames_seen++;
        gap = 1;
        check(bits == 16, "R5 sclk edges per frame", bits, 16);
        check(shreg == exp_word, "R3/R4 frame word", shreg, exp_word);
        check(!ready_bad, "R2 ready low during frame", 1, 0);
        if (auto_load) check(!auto_bad && !dac_ldac_n, "R10 ldac held low", dac_ldac_n, 0);
        else begin
          check(!ld_early, "R9 ldac idle in frame", 1, 0);
          ld_pend = 1; ld_cnt = 0;
        end
      end
      if (ld_pend) begin
        if (!dac_ldac_n) ld_cnt++;
        else if (!p_ldac) begin
          check(ld_cnt == 2*HALF, "R9 ldac pulse width", ld_cnt, 2*HALF);
          ld_pend = 0;
        end
      end
      p_sclk = dac_sclk; p_cs = dac_cs_n; p_ldac = dac_ldac_n;
    end
  end

  task automatic send(input logic [DATA_W-1:0] d, input bit mode, input bit junk);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    auto_load = mode;
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    exp_word = frame_of(d);
    frames_sent++;
    @(negedge clk);
    in_valid = 1'b0; in_data = ~d;
    check(!in_ready, "R2 ready drops after accept", in_ready, 0);
    if (junk) begin
      repeat (8) @(negedge clk);
      in_valid = 1'b1; in_data = 12'hA5A;
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    check(dac_cs_n == 1'b1, "R1 cs_n reset", dac_cs_n, 1);
    check(dac_sclk == 1'b0, "R1 sclk reset", dac_sclk, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    check(dac_ldac_n == 1'b1, "R1 ldac_n after reset", dac_ldac_n, 1);
    // directed corners (R3, R4)
    send(12'h000, 1'b0, 1'b0);
    send(12'hFFF, 1'b0, 1'b0);
    send(12'h800, 1'b1, 1'b0);
    send(12'h001, 1'b0, 1'b0);
    send(12'h0F0, 1'b0, 1'b1);   // R2 junk valid while busy
    send(12'hF0F, 1'b1, 1'b0);
    for (int i = 0; i < 50; i++) begin
      int idle;
      idle = $urandom % 6;
      repeat (idle) @(negedge clk);
      send(DATA_W'($urandom), bit'($urandom % 2), bit'(($urandom % 8) == 0));
    end
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    repeat (10) @(negedge clk);
    check(frames_seen == frames_sent, "R2 frame count", frames_seen, frames_sent);
    check(dac_cs_n && !dac_sclk, "R6 idle lines", {dac_cs_n, dac_sclk}, 2);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule